// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block is a bus-mapped countdown timer with four channels, each of which can run as one 32-bit timer, two 16-bit timers or four 8-bit timers. Every channel has three registers: a mode/clock control word, a reload word and a live counter word. Software programs the reload value, sets the mode and enables the sub-timers it wants. Each enabled sub-timer then counts down and reloads itself when it passes zero, so it fires periodically with a period of reload+1 ticks.

A sub-timer ticks either on every bus clock or on a single-cycle external tick strobe that arrives synchronous to the bus clock. Each underflow sets a sticky status bit, which software clears by writing a one to it. A single interrupt line is the OR of all status bits that software has unmasked.

Top module: `apb_interval_timer`

## Requirements
- R1: After reset every writable register and the interrupt output are zero. Address 0x00 always reads the constant 0x0A510100 and address 0x10 always reads the channel count, 4. Writes to either address change nothing.
- R2: Global registers are at these addresses: interrupt enable at 0x14, status at 0x18, sub-timer enable at 0x1C. Channel n (0..3) has its control word at 0x20+0x10·n, its reload at 0x24+0x10·n and its counter at 0x28+0x10·n. In the three global bit registers, channel c sub-timer i is at bit 4·c+i.
- R3: Control bits [2:0] select the layout: 1 gives one 32-bit timer, 2 gives two 16-bit timers and 3 gives four 8-bit timers. Any other value runs no sub-timer. Control bit 3 set to 1 makes a sub-timer tick on every bus clock. Set to 0, it ticks only on cycles where ext_tick is high.
- R4: In the cycle after a sub-timer's effective enable rises, its slice of the counter loads the matching slice of the reload register.
- R5: On each tick an enabled sub-timer decrements a nonzero slice. A zero slice is reloaded instead and the sub-timer's status bit is set.
- R6: In 16-bit mode, sub-timer 0 uses bits [15:0] and sub-timer 1 uses bits [31:16] of the reload and counter words. Each half underflows on its own.
- R7: In 8-bit mode, sub-timer i uses byte lane i of the reload and counter words. Each lane underflows on its own.
- R8: An enable bit for a sub-timer that the current mode does not provide has no effect on the counter or the status.
- R9: A sub-timer that is not enabled holds its counter slice. With the external clock selected, an enabled sub-timer does not move on cycles without ext_tick.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. An underflow in the same cycle as the clear keeps the bit set.
- R11: irq is high exactly when some status bit is set together with its interrupt-enable bit.
- R12: A write to a counter register replaces the whole word, overriding counting and loading in that cycle. The counter register always reads back the live count.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_tick | input | 1 | External count strobe, one bus-clock wide |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench drives the external tick by hand so that every count is exact. It then walks each layout through its underflow boundary. A 16-bit or 8-bit lane that borrowed across into its neighbour would change the neighbouring half or byte and set the wrong status bit. A design that loaded on level rather than on the enable edge would return the reload value after a counter preload. The bench writes zero to a set status bit, which a design with a plain write-clear would lose, and checks that irq tracks the mask. It enables sub-timers that the mode lacks, and selects a mode with no timers, where a careless decoder would count. It also lets a bus-clocked channel run without ticks and checks that its status bit gets set.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the interval timer.
// Assumes a byte-addressed bus; offsets are byte addresses.
package tmr_pkg;
    localparam int SUBS      = 4;            // sub-timer slots per channel
    localparam int OFF_ID    = 'h00;
    localparam int OFF_CFG   = 'h10;
    localparam int OFF_IEN   = 'h14;
    localparam int OFF_STS   = 'h18;
    localparam int OFF_CEN   = 'h1C;
    localparam int CH_BASE   = 'h20;
    localparam int CH_STRIDE = 'h10;
    localparam int OFF_CTRL  = 'h0;
    localparam int OFF_REL   = 'h4;
    localparam int OFF_CNT   = 'h8;
    localparam logic [31:0] TMR_ID = 32'h0A51_0100;

    typedef enum logic [2:0] {
        LAYOUT_NONE = 3'd0,
        LAYOUT_W32  = 3'd1,
        LAYOUT_W16  = 3'd2,
        LAYOUT_W8   = 3'd3
    } layout_e;
endpackage

// File: rtl/tmr_channel.sv
// One timer channel: a shared counter word split into 1, 2 or 4
// sub-timers by the layout field. Assumes ext_tick is synchronous
// to clk and one cycle wide; DW divisible by 4.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      layout,
    input  logic            use_bus_clk,
    input  logic            ext_tick,
    input  logic [SUBS-1:0] en,
    input  logic [DW-1:0]   reload,
    input  logic            cnt_wr,
    input  logic [DW-1:0]   cnt_wdata,
    output logic [DW-1:0]   count,
    output logic [SUBS-1:0] uflow
);
    localparam int HW = DW / 2;
    localparam int QW = DW / 4;

    logic            tick;
    logic [SUBS-1:0] act;
    logic [SUBS-1:0] act_q;
    logic [SUBS-1:0] ld;
    logic [DW-1:0]   count_q;
    logic [DW-1:0]   count_d;

    assign tick = use_bus_clk | ext_tick;
    assign ld   = act & ~act_q;

    // Effective enable per slot: enable bit gated by the layout.
    for (genvar s = 0; s < SUBS; s++) begin : g_act
        always_comb begin
            case (layout)
                LAYOUT_W32: act[s] = en[s] & (s == 0);
                LAYOUT_W16: act[s] = en[s] & (s < 2);
                LAYOUT_W8:  act[s] = en[s];
                default:    act[s] = 1'b0;
            endcase
        end
    end

    // One step of a slice: returns {underflow, next value}.
    function automatic logic [DW:0] step(input logic [DW-1:0] cur,
                                         input logic [DW-1:0] rel,
                                         input logic load, input logic run);
        if (load)
            return {1'b0, rel};
        if (run)
            return (cur == '0) ? {1'b1, rel} : {1'b0, cur - 1'b1};
        return {1'b0, cur};
    endfunction

    // Next counter word and underflow pulses for the current layout.
    always_comb begin
        logic [DW:0] r;
        count_d = count_q;
        uflow   = '0;
        r       = '0;
        if (cnt_wr) begin
            count_d = cnt_wdata;
        end else begin
            case (layout)
                LAYOUT_W32: begin
                    r = step(count_q, reload, ld[0], act[0] & tick);
                    count_d  = r[DW-1:0];
                    uflow[0] = r[DW];
                end
                LAYOUT_W16: begin
                    for (int s = 0; s < 2; s++) begin
                        r = step(DW'(count_q[s*HW +: HW]), DW'(reload[s*HW +: HW]),
                                 ld[s], act[s] & tick);
                        count_d[s*HW +: HW] = r[HW-1:0];
                        uflow[s] = r[DW];
                    end
                end
                LAYOUT_W8: begin
                    for (int s = 0; s < 4; s++) begin
                        r = step(DW'(count_q[s*QW +: QW]), DW'(reload[s*QW +: QW]),
                                 ld[s], act[s] & tick);
                        count_d[s*QW +: QW] = r[QW-1:0];
                        uflow[s] = r[DW];
                    end
                end
                default: ;
            endcase
        end
    end

    // Counter word and enable history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            act_q   <= '0;
        end else begin
            count_q <= count_d;
            act_q   <= act;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/tmr_irq.sv
// Combines masked status bits into one interrupt line. Purely combinational.
module tmr_irq #(
    parameter int NB = 16
) (
    input  logic [NB-1:0] status,
    input  logic [NB-1:0] mask,
    output logic          irq
);
    // Any unmasked pending bit raises the line.
    assign irq = |(status & mask);
endmodule

// File: rtl/apb_interval_timer.sv
// Four-channel interval timer on a simple peripheral bus. Holds the global
// and per-channel registers and instantiates one tmr_channel per channel.
// Assumes single-cycle access phase (no wait states) and NUM_CH*4 <= DW.
module apb_interval_timer
    import tmr_pkg::*;
#(
    parameter int          NUM_CH   = 4,
    parameter int          DW       = 32,
    parameter int          AW       = 8,
    parameter logic [31:0] ID_VALUE = TMR_ID
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    input  logic          ext_tick,
    output logic          irq
);
    localparam int NB  = NUM_CH * SUBS;
    localparam int CIW = AW - 4;

    logic            wr_en;
    logic            in_ch;
    logic [AW-1:0]   ch_off;
    logic [CIW-1:0]  ch_idx;
    logic [3:0]      reg_off;
    logic [NUM_CH-1:0] sel_ch;
    logic [NUM_CH-1:0] cnt_wr;

    logic [NB-1:0]   int_en_q;
    logic [NB-1:0]   status_q;
    logic [NB-1:0]   ch_en_q;
    logic [NB-1:0]   uf_all;
    logic [NB-1:0]   clr_mask;
    logic [3:0]      ctrl_q [NUM_CH];
    logic [DW-1:0]   rel_q  [NUM_CH];
    logic [DW-1:0]   cnt_w  [NUM_CH];

    assign wr_en   = psel & penable & pwrite;
    assign in_ch   = (paddr >= AW'(CH_BASE)) && (paddr < AW'(CH_BASE + CH_STRIDE * NUM_CH));
    assign ch_off  = paddr - AW'(CH_BASE);
    assign ch_idx  = ch_off[AW-1:4];
    assign reg_off = ch_off[3:0];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign sel_ch[n] = in_ch && (ch_idx == CIW'(n));
        assign cnt_wr[n] = wr_en && sel_ch[n] && (reg_off == 4'(OFF_CNT));
        tmr_channel #(.DW(DW)) u_ch (
            .clk        (pclk),
            .rst_n      (presetn),
            .layout     (ctrl_q[n][2:0]),
            .use_bus_clk(ctrl_q[n][3]),
            .ext_tick   (ext_tick),
            .en         (ch_en_q[n*SUBS +: SUBS]),
            .reload     (rel_q[n]),
            .cnt_wr     (cnt_wr[n]),
            .cnt_wdata  (pwdata),
            .count      (cnt_w[n]),
            .uflow      (uf_all[n*SUBS +: SUBS])
        );
    end

    // Per-channel control and reload registers.
    always_ff @(posedge pclk) begin
        for (int n = 0; n < NUM_CH; n++) begin
            if (!presetn) begin
                ctrl_q[n] <= '0;
                rel_q[n]  <= '0;
            end else if (wr_en && sel_ch[n]) begin
                if (reg_off == 4'(OFF_CTRL)) ctrl_q[n] <= pwdata[3:0];
                if (reg_off == 4'(OFF_REL))  rel_q[n]  <= pwdata;
            end
        end
    end

    assign clr_mask = (wr_en && paddr == AW'(OFF_STS)) ? pwdata[NB-1:0] : '0;

    // Global enable, mask and sticky status registers; underflow wins over clear.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            int_en_q <= '0;
            ch_en_q  <= '0;
            status_q <= '0;
        end else begin
            if (wr_en && paddr == AW'(OFF_IEN)) int_en_q <= pwdata[NB-1:0];
            if (wr_en && paddr == AW'(OFF_CEN)) ch_en_q  <= pwdata[NB-1:0];
            status_q <= (status_q & ~clr_mask) | uf_all;
        end
    end

    // Read data selection.
    always_comb begin
        prdata = '0;
        if (paddr == AW'(OFF_ID))       prdata = ID_VALUE;
        else if (paddr == AW'(OFF_CFG)) prdata = DW'(NUM_CH);
        else if (paddr == AW'(OFF_IEN)) prdata = DW'(int_en_q);
        else if (paddr == AW'(OFF_STS)) prdata = DW'(status_q);
        else if (paddr == AW'(OFF_CEN)) prdata = DW'(ch_en_q);
        else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (sel_ch[n]) begin
                    case (reg_off)
                        4'(OFF_CTRL): prdata = DW'(ctrl_q[n]);
                        4'(OFF_REL):  prdata = rel_q[n];
                        4'(OFF_CNT):  prdata = cnt_w[n];
                        default:      prdata = '0;
                    endcase
                end
            end
        end
    end

    tmr_irq #(.NB(NB)) u_irq (
        .status(status_q),
        .mask  (int_en_q),
        .irq   (irq)
    );
endmodule

// File: rtl/tmr_checker.sv
// Protocol and behaviour checks for apb_interval_timer, attached by bind.
// Watches channel 0 in detail and the global registers.
module tmr_checker #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int NB = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [AW-1:0] paddr,
    input logic [NB-1:0] wdata_lo,
    input logic [DW-1:0] prdata,
    input logic          irq,
    input logic [NB-1:0] status,
    input logic [NB-1:0] int_en,
    input logic [NB-1:0] ch_en,
    input logic [2:0]    mode0,
    input logic [DW-1:0] rel0,
    input logic [DW-1:0] cnt0
);
    logic          any_wr;
    logic          cnt0_wr;
    logic [NB-1:0] clr;

    assign any_wr  = psel && penable && pwrite;
    assign cnt0_wr = any_wr && paddr == AW'('h28);
    assign clr     = (any_wr && paddr == AW'('h18)) ? wdata_lo : '0;

    assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && paddr == AW'('h00)) |-> prdata == 32'h0A51_0100);

    assert_cfg_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && paddr == AW'('h10)) |-> prdata == DW'(4));

    assert_reload_on_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 3'd1 && ch_en[0] && !status[0] && !any_wr) |=> (!status[0] || cnt0 == rel0));

    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en[3:0] == 4'b0 && !cnt0_wr) |=> $stable(cnt0));

    assert_w0_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (|(status & int_en)));
endmodule

bind apb_interval_timer tmr_checker #(.AW(AW), .DW(DW), .NB(NB)) u_tmr_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wdata_lo(pwdata[NB-1:0]),
    .prdata  (prdata),
    .irq     (irq),
    .status  (status_q),
    .int_en  (int_en_q),
    .ch_en   (ch_en_q),
    .mode0   (ctrl_q[0][2:0]),
    .rel0    (rel_q[0]),
    .cnt0    (cnt_w[0])
);

// File: tb/test_apb_interval_timer.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them when the access phase completes.
module test_apb_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic        ext_tick = 1'b0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    apb_interval_timer i_apb_interval_timer (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel <= 1'b1; pwrite <= 1'b1; penable <= 1'b0; paddr <= a; pwdata <= d;
        @(negedge clk); penable <= 1'b1;
        @(negedge clk); psel <= 1'b0; penable <= 1'b0; pwrite <= 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); psel <= 1'b1; pwrite <= 1'b0; penable <= 1'b0; paddr <= a;
        @(negedge clk); penable <= 1'b1;
        @(negedge clk); psel <= 1'b0; penable <= 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_tick <= 1'b1;
            @(negedge clk); ext_tick <= 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // Monitor: compare each completed read against the queued expectation.
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            logic [31:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard unexpected read actual=%h expected=none", prdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (prdata !== e) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, paddr, prdata, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        // R1 reset state and constants
        chk_irq(1'b0, "R1");
        rd(8'h00, 32'h0A51_0100, "R1 id");
        rd(8'h10, 32'd4, "R1 cfg");
        rd(8'h18, 32'h0, "R1 status");
        rd(8'h1C, 32'h0, "R1 enable");
        rd(8'h20, 32'h0, "R1 ctrl");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0000_0077);
        rd(8'h00, 32'h0A51_0100, "R1 id after write");
        rd(8'h10, 32'd4, "R1 cfg after write");
        // R2 R3 R4 channel 0, 32-bit, external tick
        wr(8'h20, 32'h1);
        wr(8'h24, 32'd3);
        wr(8'h1C, 32'h1);
        rd(8'h28, 32'd3, "R4 load on enable");
        pulse(1);
        rd(8'h28, 32'd2, "R5 decrement");
        pulse(3);
        rd(8'h28, 32'd3, "R5 reload after zero");
        rd(8'h18, 32'h1, "R5 status set");
        chk_irq(1'b0, "R11 masked");
        wr(8'h14, 32'h1);
        chk_irq(1'b1, "R11 unmasked");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h1, "R10 write zero keeps");
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h0, "R10 write one clears");
        chk_irq(1'b0, "R11 cleared");
        // R12 preload
        wr(8'h28, 32'd1);
        rd(8'h28, 32'd1, "R12 preload");
        pulse(2);
        rd(8'h28, 32'd3, "R12 count from preload");
        rd(8'h18, 32'h1, "R12 underflow from preload");
        wr(8'h18, 32'h1);
        // R9 hold when disabled or without tick
        wr(8'h1C, 32'h0);
        pulse(3);
        rd(8'h28, 32'd3, "R9 hold disabled");
        rd(8'h18, 32'h0, "R9 no status disabled");
        wr(8'h28, 32'd7);
        wr(8'h1C, 32'h1);
        repeat (5) @(negedge clk);
        rd(8'h28, 32'd3, "R9 R4 no tick no move after reload");
        wr(8'h1C, 32'h0);
        // R6 16-bit on channel 1
        wr(8'h30, 32'h2);
        wr(8'h34, 32'h0002_0005);
        wr(8'h1C, 32'h30);
        rd(8'h38, 32'h0002_0005, "R6 halves loaded");
        pulse(3);
        rd(8'h38, 32'h0002_0002, "R6 halves independent");
        rd(8'h18, 32'h20, "R6 upper half status bit5");
        wr(8'h14, 32'h21);
        chk_irq(1'b1, "R11 bit5");
        wr(8'h18, 32'h20);
        chk_irq(1'b0, "R11 bit5 cleared");
        // R7 8-bit on channel 2, lanes 0 and 2
        wr(8'h40, 32'h3);
        wr(8'h44, 32'h0403_0201);
        wr(8'h1C, 32'h500);
        rd(8'h48, 32'h0003_0001, "R7 lanes loaded");
        pulse(2);
        rd(8'h48, 32'h0001_0001, "R7 lanes independent");
        rd(8'h18, 32'h100, "R7 lane0 status");
        wr(8'h18, 32'h100);
        // R8 sub-timer absent in 32-bit layout
        wr(8'h50, 32'h1);
        wr(8'h54, 32'd5);
        wr(8'h1C, 32'h2000);
        pulse(2);
        rd(8'h58, 32'h0, "R8 absent sub-timer");
        rd(8'h18, 32'h0, "R8 no status");
        // R3 no-timer layout, bus clock selected
        wr(8'h50, 32'h8);
        wr(8'h1C, 32'h1000);
        repeat (10) @(negedge clk);
        rd(8'h58, 32'h0, "R3 layout 0 idle");
        rd(8'h18, 32'h0, "R3 layout 0 no status");
        // R3 bus clock counting
        wr(8'h54, 32'd4);
        wr(8'h50, 32'h9);
        repeat (20) @(negedge clk);
        rd(8'h18, 32'h1000, "R3 bus clock underflow");
        rd(8'h28, 32'd3, "R9 other channel held");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule